// File: doc/BRIEF.md
# Masked Control Register Bank

This block holds a small set of control registers. They are reached over a word-addressed bus that has a write strobe, a read strobe, an address, write data and read data. Every register is built with its own read-only bit mask. Software cannot change any bit that is set in the mask, whatever kind of write it uses. A register whose mask is all ones is therefore a constant that can only be read. A register whose mask is all zeros can be written in full.

Each register owns a slot of four consecutive word addresses. The first word of the slot is the base address, where a write replaces the writable bits. Registers that are built with aliases also decode the next three words. A write to base+1 sets bits, a write to base+2 clears bits and a write to base+3 inverts bits. In all three cases only the data bits that fall outside the mask take effect. A read of the base address or of any alias returns the register's value. Read data is registered and appears one cycle after the read strobe.

Masks, reset values and the per-register alias enables are elaboration-time parameters. The reset is asynchronous and active low. It loads every register with its reset value and clears the read data.

Top module: `masked_reg_bank`

## Requirements
- R1: While reset is asserted, and after it is released, every register holds its reset value and rsp_rdata is zero.
- R2: A write to a base address (word offset 0 of a slot) stores (old & mask) | (wdata & ~mask), so masked bits never change.
- R3: A register with an all-ones mask keeps its value under every kind of write, and a register with an all-zero mask takes the full write data.
- R4: On a register with aliases, a write to base+1 (SET) performs reg |= (wdata & ~mask).
- R5: On a register with aliases, a write to base+2 (CLR) performs reg &= ~(wdata & ~mask).
- R6: On a register with aliases, a write to base+3 (TOG) performs reg ^= (wdata & ~mask).
- R7: A write to an alias offset of a register built without aliases, or to an address at or above 4*NUM_REGS, changes no register.
- R8: A read of a base address, or of any alias of a register that has aliases, returns that register's current value on rsp_rdata in the cycle after the read strobe.
- R9: A read of an unmapped address (as defined in R7) returns zero.
- R10: When a read and a write are issued in the same cycle, the read returns the value from before the write, and rsp_rdata holds its value in every cycle without a read strobe.
- R11: A write changes only the one register whose slot it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_wr | input | 1 | Write strobe, one cycle per write |
| req_rd | input | 1 | Read strobe, one cycle per read |
| req_addr | input | ADDR_W | Word address: register slot in the upper bits, access kind in the two lowest bits |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Registered read data |

## Verification
A fault in the update logic, such as a mask applied to the wrong operand, a mixed-up alias kind or a write reaching the wrong slot, is stored in a register. It shows up on rsp_rdata at the first read of that register, one cycle after the read strobe. A decode fault that leaves an unmapped address selected shows up straight away, as non-zero read data for that address or as a change in a register that should have ignored the write. The bench keeps a model of every register, reads back after each burst of random traffic, and runs directed cases on the all-ones and all-zero masks and on alias offsets that have no alias.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

  // Access kind, taken from the two lowest address bits of a register slot.
  // The encoding is the address offset within the slot.
  typedef enum logic [1:0] {
    MRB_OP_WRITE = 2'd0,
    MRB_OP_SET   = 2'd1,
    MRB_OP_CLR   = 2'd2,
    MRB_OP_TOG   = 2'd3
  } mrb_op_e;

  localparam int unsigned MRB_SLOT_BITS = 2;

endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
  import mrb_pkg::*;
#(
  parameter int unsigned         NUM_REGS = 6,
  parameter int unsigned         ADDR_W   = 6,
  parameter logic [NUM_REGS-1:0] ALIAS_EN = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_REGS-1:0] sel,
  output logic                hit,
  output mrb_op_e             op
);

  localparam int unsigned IDX_W = ADDR_W - MRB_SLOT_BITS;

  logic [IDX_W-1:0]         slot;
  logic [MRB_SLOT_BITS-1:0] offs;

  assign slot = addr[ADDR_W-1:MRB_SLOT_BITS];
  assign offs = addr[MRB_SLOT_BITS-1:0];
  assign op   = mrb_op_e'(offs);

  // One slot comparator per register. Alias offsets decode only where enabled.
  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_slot
    if (ALIAS_EN[gi]) begin : g_alias
      assign sel[gi] = (slot == IDX_W'(gi));
    end else begin : g_plain
      assign sel[gi] = (slot == IDX_W'(gi)) && (offs == '0);
    end
  end

  assign hit = |sel;

endmodule

// File: rtl/mrb_cell.sv
module mrb_cell
  import mrb_pkg::*;
#(
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] MASK    = '0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  mrb_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);

  logic [DATA_W-1:0] eff;
  logic [DATA_W-1:0] q_nxt;

  // Only the writable bits of the data take part in any access kind.
  assign eff = wdata & ~MASK;

  always_comb begin
    unique case (op)
      MRB_OP_WRITE: q_nxt = (q & MASK) | eff;
      MRB_OP_SET:   q_nxt = q | eff;
      MRB_OP_CLR:   q_nxt = q & ~eff;
      MRB_OP_TOG:   q_nxt = q ^ eff;
      default:      q_nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (we) begin
      q <= q_nxt;
    end
  end

  AST_MASKED_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & MASK) == ($past(q) & MASK))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R11
  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == MRB_OP_SET) |=> ((q & $past(q)) == $past(q))); // R4
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == MRB_OP_CLR) |=> ((q & ~$past(q)) == '0)); // R5
  AST_TOG_WRITABLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == MRB_OP_TOG) |=> (((q ^ $past(q)) & MASK) == '0)); // R6

endmodule

// File: rtl/mrb_rdmux.sv
module mrb_rdmux #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned DATA_W   = 32
) (
  input  logic [NUM_REGS-1:0] sel,
  input  logic [DATA_W-1:0]   regs [NUM_REGS],
  output logic [DATA_W-1:0]   rd_val
);

  // AND-OR selection: an empty select (unmapped address) yields zero.
  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      rd_val = rd_val | (regs[i] & {DATA_W{sel[i]}});
    end
  end

endmodule

// File: rtl/masked_reg_bank.sv
module masked_reg_bank
  import mrb_pkg::*;
#(
  parameter int unsigned                NUM_REGS = 6,
  parameter int unsigned                DATA_W   = 32,
  parameter int unsigned                ADDR_W   = $clog2(NUM_REGS * 4) + 1,
  parameter logic [NUM_REGS*DATA_W-1:0] MASKS    = {
    32'hFFE2_0F80, 32'hF01F_EF80, 32'hFFFF_FFFF,
    32'h0000_0000, 32'hC000_0000, 32'h4040_4040},
  parameter logic [NUM_REGS*DATA_W-1:0] RST_VALS = {
    32'h0001_3042, 32'h0402_0000, 32'hDEAD_BEEF,
    32'hFFFF_FFFF, 32'h4000_0001, 32'h1818_1818},
  parameter logic [NUM_REGS-1:0]        ALIAS_EN = 6'b10_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic              req_rd,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic [NUM_REGS-1:0] sel;
  logic                hit;
  mrb_op_e             op;
  logic [DATA_W-1:0]   regs [NUM_REGS];
  logic [DATA_W-1:0]   rd_val;
  logic [DATA_W-1:0]   rdata_nxt;

  mrb_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .ALIAS_EN (ALIAS_EN)
  ) u_decode (
    .addr (req_addr),
    .sel  (sel),
    .hit  (hit),
    .op   (op)
  );

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    mrb_cell #(
      .DATA_W  (DATA_W),
      .MASK    (MASKS[gi*DATA_W +: DATA_W]),
      .RST_VAL (RST_VALS[gi*DATA_W +: DATA_W])
    ) u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (req_wr & sel[gi]),
      .op    (op),
      .wdata (req_wdata),
      .q     (regs[gi])
    );
  end

  mrb_rdmux #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
  ) u_rdmux (
    .sel    (sel),
    .regs   (regs),
    .rd_val (rd_val)
  );

  // Read data register: loads only on a read strobe and samples pre-write state.
  always_comb begin
    rdata_nxt = rsp_rdata;
    if (req_rd) begin
      rdata_nxt = rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else begin
      rsp_rdata <= rdata_nxt;
    end
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel)); // R11
  AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !hit) |=> (rsp_rdata == '0)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> $stable(rsp_rdata)); // R10
  AST_UNMAPPED_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !hit) |=> $stable(regs[0])); // R7

endmodule

// File: tb/masked_reg_bank_tb.sv
module masked_reg_bank_tb;

  localparam int unsigned NR = 6;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = $clog2(NR * 4) + 1;
  localparam logic [NR*DW-1:0] T_MASKS = {
    32'hFFE2_0F80, 32'hF01F_EF80, 32'hFFFF_FFFF,
    32'h0000_0000, 32'hC000_0000, 32'h4040_4040};
  localparam logic [NR*DW-1:0] T_RST = {
    32'h0001_3042, 32'h0402_0000, 32'hDEAD_BEEF,
    32'hFFFF_FFFF, 32'h4000_0001, 32'h1818_1818};
  localparam logic [NR-1:0] T_ALIAS = 6'b10_0011;

  logic          clk;
  logic          rst_n;
  logic          req_wr;
  logic          req_rd;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] rsp_rdata;

  int n_chk;
  int n_err;
  logic [DW-1:0] model [NR];

  masked_reg_bank #(
    .NUM_REGS (NR),
    .DATA_W   (DW),
    .ADDR_W   (AW),
    .MASKS    (T_MASKS),
    .RST_VALS (T_RST),
    .ALIAS_EN (T_ALIAS)
  ) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_wr    (req_wr),
    .req_rd    (req_rd),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_rdata (rsp_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [DW-1:0] mask_of(int i);
    return T_MASKS[i*DW +: DW];
  endfunction

  function automatic bit mapped(logic [AW-1:0] a);
    int idx = int'(a >> 2);
    int sub = int'(a & 3);
    return (idx < NR) && (sub == 0 || T_ALIAS[idx]);
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [AW-1:0] a);
    if (mapped(a)) return model[int'(a >> 2)];
    return '0;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [DW-1:0] d);
    int idx = int'(a >> 2);
    int sub = int'(a & 3);
    logic [DW-1:0] e;
    if (!mapped(a)) return;
    e = d & ~mask_of(idx);
    case (sub)
      0: model[idx] = (model[idx] & mask_of(idx)) | e;
      1: model[idx] = model[idx] | e;
      2: model[idx] = model[idx] & ~e;
      default: model[idx] = model[idx] ^ e;
    endcase
  endtask

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_wr = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk);
    req_rd = 1'b1; req_addr = a;
    @(negedge clk);
    req_rd = 1'b0;
    v = rsp_rdata;
  endtask

  task automatic read_check(string tag, logic [AW-1:0] a);
    logic [DW-1:0] v;
    do_read(a, v);
    check(tag, v, exp_read(a));
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < NR; i++) read_check(tag, AW'(i * 4));
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog (all) act=timeout exp=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int unsigned seed;
    n_chk = 0; n_err = 0;
    req_wr = 1'b0; req_rd = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    for (int i = 0; i < NR; i++) model[i] = T_RST[i*DW +: DW];
    repeat (3) @(negedge clk);
    check("R1 rdata in reset", rsp_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", rsp_rdata, '0);
    check_all("R1 reset value");

    // R2: base write on a partly masked register
    do_write(AW'(4), 32'h3FFF_FFFF);
    do_read(AW'(4), v);
    check("R2 masked base write", v, 32'h7FFF_FFFF);

    // R4 / R5 / R6 on register 0 (mask 0x40404040)
    do_write(AW'(1), 32'hFFFF_FFFF);
    do_read(AW'(0), v);
    check("R4 set alias", v, 32'hBFBF_BFBF);
    do_write(AW'(2), 32'hFFFF_FFFF);
    do_read(AW'(2), v);
    check("R5 clr alias", v, 32'h0000_0000);
    do_write(AW'(3), 32'h0F4F_0F0F);
    do_read(AW'(3), v);
    check("R6 tog alias", v, 32'h0F0F_0F0F);
    do_read(AW'(1), v);
    check("R8 read via alias", v, 32'h0F0F_0F0F);

    // R3: fully read-only register 3, fully writable register 2
    do_write(AW'(12), 32'h0000_0000);
    do_read(AW'(12), v);
    check("R3 read-only reg", v, 32'hDEAD_BEEF);
    do_write(AW'(8), 32'h1234_5678);
    do_read(AW'(8), v);
    check("R3 writable reg", v, 32'h1234_5678);

    // R7 / R9: alias offset of a register without aliases, and out of range
    do_write(AW'(9), 32'hFFFF_FFFF);
    do_read(AW'(8), v);
    check("R7 no-alias offset ignored", v, 32'h1234_5678);
    do_write(AW'(NR * 4 + 1), 32'hA5A5_A5A5);
    check_all("R7 out-of-range write ignored");
    do_read(AW'(9), v);
    check("R9 unmapped read zero", v, '0);
    do_read(AW'((1 << AW) - 1), v);
    check("R9 top address zero", v, '0);

    // R10: read and write in the same cycle return the old value
    @(negedge clk);
    req_wr = 1'b1; req_rd = 1'b1; req_addr = AW'(8); req_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    req_wr = 1'b0; req_rd = 1'b0;
    check("R10 read before write", rsp_rdata, 32'h1234_5678);
    model_write(AW'(8), 32'hCAFE_F00D);
    repeat (2) @(negedge clk);
    check("R10 rdata held", rsp_rdata, 32'h1234_5678);
    read_check("R10 new value visible", AW'(8));

    // R11: one write touches only its own slot
    do_write(AW'(20), 32'hFFFF_FFFF);
    check_all("R11 only addressed reg");

    // Random traffic against the model
    seed = 32'd20240611;
    void'($urandom(seed));
    for (int n = 0; n < 600; n++) begin
      a = AW'($urandom);
      d = $urandom;
      if ($urandom % 3 != 0) begin
        do_write(a, d);
      end else begin
        do_read(a, v);
        check(mapped(a) ? "R8 random read" : "R9 random read", v, exp_read(a));
      end
    end
    check_all("R11 final state");

    finish_run();
  end

endmodule